// File: doc/BRIEF.md
# Hitless Reference Switchover Controller

This block sequences the recovery of a clock PLL when its input reference suddenly jumps in phase. It receives one signed phase-error sample per phase comparison. Each sample is a fixed-point count of oscillator cycles with `FRAC_BITS` fractional bits, measured as reference edge minus feedback edge. From these samples the block drives the phase-detector enable, the loop-bandwidth select and the feedback divider phase offset.

After reset the controller waits for the loop to lock for the first time, and only then arms. Once armed, a single large phase transient counts as loss of lock and starts a fixed sequence. The sequence steps through these states:

- `GATE_NBW`: the detector is gated off and narrow bandwidth is forced.
- `BUILDOUT` (optional): the feedback phase is advanced by the nearest whole number of oscillator cycles, absorbing most of the step.
- `RELOCK_WAIT`: the detector is re-enabled, and the controller waits for eight consecutive in-window comparisons.
- `WBW_TIMER`: narrow bandwidth is held for a fixed interval, then released, and the controller re-arms.

Named transitions: IDLE_UNARMED→ARMED on first lock. ARMED→GATE_NBW on loss of lock. GATE_NBW→BUILDOUT when build-out is active, otherwise GATE_NBW→RELOCK_WAIT. BUILDOUT→RELOCK_WAIT after one cycle. RELOCK_WAIT→WBW_TIMER on re-lock. WBW_TIMER→ARMED on timer expiry. Any state goes to IDLE_UNARMED on reset.

Top module: `hitless_switch_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in IDLE_UNARMED. The state codes on `state_o` are IDLE_UNARMED=0, ARMED=1, GATE_NBW=2, BUILDOUT=3, RELOCK_WAIT=4, WBW_TIMER=5. After reset `pd_en`=1, `armed`=0, `fb_phase`=0 and `nbw_sel` follows `nbw_req`.
- R2: While unarmed, a loss-of-lock sample has no effect. The controller arms (state 1, `armed`=1) one cycle after the eighth consecutive in-window sample.
- R3: In ARMED, a valid sample with |error| >= `LOL_THR` moves the controller to GATE_NBW at that clock edge: `pd_en`=0 and `nbw_sel`=1. A sample with `WIN_THR` < |error| < `LOL_THR` leaves it armed.
- R4: With build-out active (`PBO_PRESENT`=1 and `pbo_en`=1), GATE_NBW is followed by one cycle of BUILDOUT. On leaving BUILDOUT, `fb_phase` becomes (`fb_phase` + floor(e/2^FRAC_BITS + 1/2)) mod `DIV_N`, where e is the error captured at the trigger. `fb_phase` changes at no other time except reset.
- R5: With `pbo_en`=0, GATE_NBW goes straight to RELOCK_WAIT after one cycle. `pd_en` returns to 1 and `fb_phase` is unchanged.
- R6: In RELOCK_WAIT, eight consecutive valid samples with |error| <= `WIN_THR` lead to WBW_TIMER one cycle after the eighth. Any valid sample outside the window clears the count, and cycles without `cmp_valid` leave the count unchanged.
- R7: WBW_TIMER lasts exactly `HOLD_CYC` cycles, then returns to ARMED and releases the controller's narrow-bandwidth forcing.
- R8: `nbw_req`=1 forces `nbw_sel`=1 in every state. The end-of-sequence release removes only the controller's own forcing.
- R9: Loss-of-lock samples during GATE_NBW, BUILDOUT or WBW_TIMER are ignored. During RELOCK_WAIT they only clear the consecutive count. Build-out uses the error captured at the first trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | A phase comparison result is present this cycle |
| phase_err | input | PE_W | Signed phase error, oscillator cycles with FRAC_BITS fraction bits |
| pbo_en | input | 1 | Enable feedback phase build-out |
| nbw_req | input | 1 | External narrow-bandwidth request |
| pd_en | output | 1 | Phase detector enable |
| nbw_sel | output | 1 | Narrow loop bandwidth selected |
| armed | output | 1 | Controller is armed and watching for loss of lock |
| fb_phase | output | $clog2(DIV_N) | Feedback divider phase offset, modulo DIV_N |
| state_o | output | 3 | Current sequencer state code |

## Verification
Two functions can act in the same cycle: the end-of-timer release of narrow bandwidth and the external narrow-bandwidth request. The bench holds `nbw_req` high through WBW_TIMER and drops it in the timer's last cycle. It then judges that `nbw_sel` stays high in that cycle and falls only once ARMED is reached. A second pairing puts a loss-of-lock sample inside the GATE_NBW cycle that precedes build-out. The expected feedback phase must still come from the first captured error.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        S_IDLE_UNARMED = 3'd0,
        S_ARMED        = 3'd1,
        S_GATE_NBW     = 3'd2,
        S_BUILDOUT     = 3'd3,
        S_RELOCK_WAIT  = 3'd4,
        S_WBW_TIMER    = 3'd5
    } hs_state_e;

    // Non-negative remainder of v modulo n (n > 0).
    function automatic int wrap_mod(input int v, input int n);
        int r;
        r = v % n;
        if (r < 0) r = r + n;
        return r;
    endfunction

endpackage

// File: rtl/hs_phase_classify.sv
module hs_phase_classify #(
    parameter int PE_W    = 12,
    parameter int LOL_THR = 40,
    parameter int WIN_THR = 20
) (
    input  logic signed [PE_W-1:0] phase_err,
    output logic                   lol_hit,
    output logic                   in_window
);
    localparam int MW = PE_W + 1;
    localparam logic [MW-1:0] LOL_T = LOL_THR[MW-1:0];
    localparam logic [MW-1:0] WIN_T = WIN_THR[MW-1:0];

    logic signed [MW-1:0] err_ext;
    logic        [MW-1:0] err_mag;

    assign err_ext = {phase_err[PE_W-1], phase_err};

    always_comb begin
        if (err_ext[MW-1]) err_mag = MW'(-err_ext);
        else               err_mag = err_ext;
    end

    assign lol_hit   = (err_mag >= LOL_T);
    assign in_window = (err_mag <= WIN_T);

endmodule

// File: rtl/hs_lock_counter.sv
module hs_lock_counter #(
    parameter int LOCK_CNT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sample,
    input  logic good,
    output logic done
);
    localparam int CW = $clog2(LOCK_CNT + 1);
    localparam logic [CW-1:0] TOP = CW'(LOCK_CNT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
        end else if (sample) begin
            if (!good)            cnt_q <= '0;
            else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == TOP);

endmodule

// File: rtl/hs_hold_timer.sv
module hs_hold_timer #(
    parameter int HOLD_CYC = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(HOLD_CYC - 1);

    logic [TW-1:0] t_q;

    always_ff @(posedge clk) begin
        if (rst || !run) t_q <= '0;
        else if (t_q != LAST) t_q <= t_q + 1'b1;
    end

    assign expired = run && (t_q == LAST);

endmodule

// File: rtl/hs_buildout_acc.sv
module hs_buildout_acc #(
    parameter int PE_W      = 12,
    parameter int FRAC_BITS = 4,
    parameter int DIV_N     = 16,
    localparam int FB_W     = $clog2(DIV_N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture,
    input  logic signed [PE_W-1:0] err_in,
    input  logic                   load,
    output logic [FB_W-1:0]        fb_phase
);
    localparam int MW     = PE_W + 1;
    localparam int HALF_I = 1 << (FRAC_BITS - 1);
    localparam logic signed [MW-1:0] RND_HALF = HALF_I[MW-1:0];

    logic signed [PE_W-1:0] err_q;
    logic signed [MW-1:0]   err_ext;
    logic signed [MW-1:0]   err_rnd;
    logic        [FB_W-1:0] fb_q;
    logic        [FB_W-1:0] fb_d;

    always_ff @(posedge clk) begin
        if (rst)          err_q <= '0;
        else if (capture) err_q <= err_in;
    end

    assign err_ext = {err_q[PE_W-1], err_q};
    assign err_rnd = (err_ext + RND_HALF) >>> FRAC_BITS;

    always_comb begin
        int sum;
        sum  = int'(fb_q) + int'(err_rnd);
        fb_d = FB_W'(hs_pkg::wrap_mod(sum, DIV_N));
    end

    always_ff @(posedge clk) begin
        if (rst)       fb_q <= '0;
        else if (load) fb_q <= fb_d;
    end

    assign fb_phase = fb_q;

endmodule

// File: rtl/hitless_switch_ctrl.sv
module hitless_switch_ctrl #(
    parameter int PE_W        = 12,
    parameter int FRAC_BITS   = 4,
    parameter int LOL_THR     = 40,
    parameter int WIN_THR     = 20,
    parameter int LOCK_CNT    = 8,
    parameter int HOLD_CYC    = 28,
    parameter int DIV_N       = 16,
    parameter bit PBO_PRESENT = 1'b1,
    localparam int FB_W       = $clog2(DIV_N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmp_valid,
    input  logic signed [PE_W-1:0] phase_err,
    input  logic                   pbo_en,
    input  logic                   nbw_req,
    output logic                   pd_en,
    output logic                   nbw_sel,
    output logic                   armed,
    output logic [FB_W-1:0]        fb_phase,
    output logic [2:0]             state_o
);
    import hs_pkg::*;

    hs_state_e state_q, state_d;

    logic lol_hit, in_window;
    logic lock_done, hold_done;
    logic cnt_enable, trigger, build_go;
    logic force_nbw;

    hs_phase_classify #(
        .PE_W(PE_W), .LOL_THR(LOL_THR), .WIN_THR(WIN_THR)
    ) u_classify (
        .phase_err(phase_err),
        .lol_hit  (lol_hit),
        .in_window(in_window)
    );

    assign cnt_enable = (state_q == S_IDLE_UNARMED) || (state_q == S_RELOCK_WAIT);

    hs_lock_counter #(.LOCK_CNT(LOCK_CNT)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .enable(cnt_enable),
        .sample(cmp_valid),
        .good  (in_window),
        .done  (lock_done)
    );

    hs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == S_WBW_TIMER),
        .expired(hold_done)
    );

    assign trigger  = (state_q == S_ARMED) && cmp_valid && lol_hit;
    assign build_go = PBO_PRESENT && pbo_en;

    generate
        if (PBO_PRESENT) begin : g_pbo
            hs_buildout_acc #(
                .PE_W(PE_W), .FRAC_BITS(FRAC_BITS), .DIV_N(DIV_N)
            ) u_acc (
                .clk     (clk),
                .rst     (rst),
                .capture (trigger),
                .err_in  (phase_err),
                .load    (state_q == S_BUILDOUT),
                .fb_phase(fb_phase)
            );
        end else begin : g_no_pbo
            assign fb_phase = '0;
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE_UNARMED;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE_UNARMED: if (lock_done) state_d = S_ARMED;
            S_ARMED:        if (trigger)   state_d = S_GATE_NBW;
            S_GATE_NBW:     state_d = build_go ? S_BUILDOUT : S_RELOCK_WAIT;
            S_BUILDOUT:     state_d = S_RELOCK_WAIT;
            S_RELOCK_WAIT:  if (lock_done) state_d = S_WBW_TIMER;
            S_WBW_TIMER:    if (hold_done) state_d = S_ARMED;
            default:        state_d = S_IDLE_UNARMED;
        endcase
    end

    // Outputs
    always_comb begin
        pd_en     = 1'b1;
        force_nbw = 1'b0;
        armed     = 1'b0;
        unique case (state_q)
            S_IDLE_UNARMED: ;
            S_ARMED:        armed = 1'b1;
            S_GATE_NBW,
            S_BUILDOUT:     begin pd_en = 1'b0; force_nbw = 1'b1; end
            S_RELOCK_WAIT,
            S_WBW_TIMER:    force_nbw = 1'b1;
            default:        ;
        endcase
        nbw_sel = force_nbw || nbw_req;
    end

    assign state_o = state_q;

endmodule

// File: rtl/hs_ctrl_chk.sv
module hs_ctrl_chk #(
    parameter int PE_W    = 12,
    parameter int LOL_THR = 40,
    parameter int FB_W    = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cmp_valid,
    input logic signed [PE_W-1:0] phase_err,
    input logic                   pbo_en,
    input logic                   nbw_req,
    input logic                   pd_en,
    input logic                   nbw_sel,
    input logic                   armed,
    input logic [FB_W-1:0]        fb_phase,
    input logic [2:0]             state_o
);
    logic big_err;
    assign big_err = (int'(phase_err) >= LOL_THR) || (int'(phase_err) <= -LOL_THR);

    p_unarmed_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1));

    p_gate_on_lol_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && cmp_valid && big_err) |=> (!pd_en && nbw_sel && state_o == 3'd2));

    p_fb_only_buildout_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o != 3'd3) |=> $stable(fb_phase));

    p_skip_buildout_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && !pbo_en) |=> (state_o == 3'd4 && pd_en));

    p_release_armed_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(nbw_sel) |-> (!nbw_req && (state_o == 3'd1 || state_o == 3'd0)));

    p_request_wins_r8: assert property (@(posedge clk) disable iff (rst)
        nbw_req |-> nbw_sel);

endmodule

bind hitless_switch_ctrl hs_ctrl_chk #(
    .PE_W(PE_W), .LOL_THR(LOL_THR), .FB_W(FB_W)
) u_hs_chk (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .phase_err(phase_err),
    .pbo_en(pbo_en), .nbw_req(nbw_req), .pd_en(pd_en), .nbw_sel(nbw_sel),
    .armed(armed), .fb_phase(fb_phase), .state_o(state_o)
);

// File: tb/tb_hitless_switch_ctrl.sv
module tb_hitless_switch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PE_W = 12;
    localparam int HOLD = 28;
    localparam int NV = 7;
    localparam int VEC_ERR [NV] = '{40, -40, -72, 300, -41, 41, 56};
    localparam int VEC_FB  [NV] = '{3, 1, 13, 0, 13, 0, 4};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_valid = 1'b0;
    logic signed [PE_W-1:0] phase_err = '0;
    logic pbo_en = 1'b1;
    logic nbw_req = 1'b0;
    logic pd_en, nbw_sel, armed;
    logic [3:0] fb_phase;
    logic [2:0] state_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hitless_switch_ctrl dut (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .phase_err(phase_err),
        .pbo_en(pbo_en), .nbw_req(nbw_req), .pd_en(pd_en), .nbw_sel(nbw_sel),
        .armed(armed), .fb_phase(fb_phase), .state_o(state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cmp(input int e);
        cmp_valid = 1'b1;
        phase_err = PE_W'(e);
        step();
        cmp_valid = 1'b0;
        phase_err = '0;
    endtask

    task automatic good_n(input int n);
        for (int i = 0; i < n; i++) cmp(0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 state", state_o, 0);
        chk("R1 pd_en", pd_en, 1);
        chk("R1 nbw_sel", nbw_sel, 0);
        chk("R1 fb_phase", fb_phase, 0);
        chk("R1 armed", armed, 0);

        // R2 loss of lock while unarmed ignored
        cmp(100);
        chk("R2 unarmed lol state", state_o, 0);
        chk("R2 unarmed lol pd_en", pd_en, 1);
        chk("R2 unarmed lol nbw", nbw_sel, 0);
        // R6 an out-of-window sample breaks the run
        good_n(7);
        cmp(25);
        good_n(7);
        step();
        chk("R6 broken run not armed", state_o, 0);
        cmp(0);
        chk("R2 eighth sample still idle", armed, 0);
        step();
        chk("R2 armed", armed, 1);

        // R3 marginal error does not trigger
        cmp(25);
        chk("R3 marginal stays armed", state_o, 1);

        // R4 build-out rounding vectors
        for (int v = 0; v < NV; v++) begin
            cmp(VEC_ERR[v]);
            chk("R3 gate state", state_o, 2);
            chk("R3 gate pd_en", pd_en, 0);
            chk("R3 gate nbw", nbw_sel, 1);
            step();
            chk("R4 buildout state", state_o, 3);
            step();
            chk("R4 relock state", state_o, 4);
            chk("R4 fb_phase", fb_phase, VEC_FB[v]);
            good_n(8);
            step();
            chk("R6 hold entered", state_o, 5);
            for (int k = 0; k < HOLD - 1; k++) step();
            chk("R7 hold last cycle", state_o, 5);
            step();
            chk("R7 rearmed", state_o, 1);
            chk("R7 nbw released", nbw_sel, 0);
        end

        // R5 build-out disabled
        pbo_en = 1'b0;
        cmp(-200);
        chk("R5 gate", state_o, 2);
        step();
        chk("R5 direct relock", state_o, 4);
        chk("R5 pd_en back", pd_en, 1);
        chk("R5 fb unchanged", fb_phase, 4);
        // R6/R9 lol in relock clears count only; idle cycles keep it
        good_n(5);
        step();
        cmp(100);
        chk("R9 relock lol stays", state_o, 4);
        good_n(4);
        step(); step();
        good_n(3);
        step();
        chk("R6 seven not enough", state_o, 4);
        cmp(0);
        step();
        chk("R6 relock after eight", state_o, 5);
        // R9 lol during hold ignored; R8 request held over expiry
        cmp(150);
        chk("R9 hold lol ignored", state_o, 5);
        nbw_req = 1'b1;
        for (int k = 0; k < HOLD - 2; k++) step();
        chk("R7 last hold cycle", state_o, 5);
        nbw_req = 1'b0;
        #1;
        chk("R8 nbw during last hold", nbw_sel, 1);
        step();
        chk("R7 armed after expiry", state_o, 1);
        chk("R7 nbw falls with release", nbw_sel, 0);

        // R8 request while armed
        nbw_req = 1'b1;
        #1;
        chk("R8 armed request nbw", nbw_sel, 1);
        chk("R8 armed request pd", pd_en, 1);
        step();
        chk("R8 still armed", armed, 1);
        nbw_req = 1'b0;

        // R9 lol during gate uses first captured error
        pbo_en = 1'b1;
        cmp(40);
        chk("R9 gate", state_o, 2);
        cmp(-300);
        chk("R9 buildout after gate lol", state_o, 3);
        step();
        chk("R9 fb uses first error", fb_phase, 7);

        // R1 reset mid-sequence
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 reset state again", state_o, 0);
        chk("R1 reset fb", fb_phase, 0);
        chk("R1 reset pd_en", pd_en, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule